// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. Between two edges, a single combinational path fetches the instruction addressed by the program counter and decodes it. The same path reads two source registers, runs the ALU, optionally accesses data memory, and forms the next program counter. The edge then commits the register write, the memory write and the new PC together. The core supports register-to-register arithmetic and logic, word load, word store and branch-if-equal. Its instruction memory, data memory and 32-entry register file are internal arrays.

A test environment or boot controller fills both memories through a load port while reset is held low, then releases reset. Progress is observed through a read-only debug port into the register file and through the current program counter. The longest combinational path is the load path: fetch, register read, address add, memory read, then write-back mux. That path sets the minimum clock period.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0, every register reads 0 on the debug port, and no executed instruction writes the register file or data memory.
- R2: pc_o advances by 4 on each rising edge unless a branch is taken. The instruction is fetched from instruction-memory word pc_o/4. Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0].
- R3: With opcode 0, funct selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). The result is written to rd. Any other funct writes nothing.
- R4: Opcode 35 loads data-memory word (rs + sign-extended immediate)/4 into rt. Opcode 43 stores rt to the same address and writes no register.
- R5: Opcode 4 compares rs and rt by subtraction. If the difference is zero, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R6: Register 0 always reads 0, and writes to it are discarded.
- R7: Any opcode other than 0, 4, 35 and 43 is a no-op that only advances the PC by 4.
- R8: Source operands are the register values before the edge, so an instruction that reads and writes the same register uses the old value.
- R9: While rst_ni is low, prog_we_i writes prog_data_i to word prog_addr_i of data memory if prog_dmem_i is 1, and of instruction memory if prog_dmem_i is 0. With rst_ni high, prog_we_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_we_i | input | 1 | Load-port write strobe, honoured only in reset |
| prog_dmem_i | input | 1 | Load-port target: 1 data memory, 0 instruction memory |
| prog_addr_i | input | LOAD_AW | Load-port word address |
| prog_data_i | input | XLEN | Load-port write data |
| dbg_addr_i | input | 5 | Debug register index |
| dbg_data_o | output | XLEN | Value of the indexed register |
| pc_o | output | XLEN | Current program counter |

## Verification
The register read for an instruction and its write-back land on the same edge. So does a store and a later load of the same word through the combinational memory path. A doubling instruction (add r2,r2,r2) provokes the first case and must leave 10 rather than 20 from 5. A store followed by a load with a negative base offset provokes the second. A load-port write issued while a branch self-loop is spinning must change neither the loop nor any register.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    wb_mem;
    logic    dm_we;
    logic    branch;
    logic    use_imm;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{rf_we: 1'b0, dst_rd: 1'b0, wb_mem: 1'b0, dm_we: 1'b0,
               branch: 1'b0, use_imm: 1'b0, alu_op: ALU_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.rf_we  = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_SW: begin
        ctrl_o.dm_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = '0;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  input  logic [AW-1:0] ra_dbg_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  output logic [W-1:0]  rd_dbg_o
);
  logic [W-1:0] regs_q [NREG];

  // entry 0 has no storage: it stays at reset value forever
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))  regs_q[g] <= wdata_i;
    end
  end

  assign rd_a_o   = regs_q[ra_a_i];
  assign rd_b_o   = regs_q[ra_b_i];
  assign rd_dbg_o = regs_q[ra_dbg_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = (IMEM_WORDS > DMEM_WORDS) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic               prog_dmem_i,
  input  logic [LOAD_AW-1:0] prog_addr_i,
  input  logic [XLEN-1:0]    prog_data_i,
  input  logic [4:0]         dbg_addr_i,
  output logic [XLEN-1:0]    dbg_data_o,
  output logic [XLEN-1:0]    pc_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target;
  logic [31:0]     instr;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rd, wb_data;
  logic            alu_zero, br_taken, rf_we, dm_we;
  logic [4:0]      rf_waddr;

  // fetch
  assign instr     = imem[pc_q[IAW+1:2]];
  assign pc_plus4  = pc_q + XLEN'(4);
  assign imm_ext   = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign br_target = pc_plus4 + (imm_ext << 2);

  sc_decoder u_dec (
    .opcode_i(instr[31:26]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );

  assign rf_we    = ctrl.rf_we & rst_ni;
  assign dm_we    = ctrl.dm_we & rst_ni;
  assign rf_waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (wb_data),
    .ra_a_i  (instr[25:21]),
    .ra_b_i  (instr[20:16]),
    .ra_dbg_i(dbg_addr_i),
    .rd_a_o  (rs_val),
    .rd_b_o  (rt_val),
    .rd_dbg_o(dbg_data_o)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i   (rs_val),
    .b_i   (alu_b),
    .op_i  (ctrl.alu_op),
    .y_o   (alu_y),
    .zero_o(alu_zero)
  );

  assign mem_rd  = dmem[alu_y[DAW+1:2]];
  assign wb_data = ctrl.wb_mem ? mem_rd : alu_y;

  assign br_taken = ctrl.branch & alu_zero;
  assign pc_next  = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  // memories carry no reset; rst_ni only steers which writer owns them
  always_ff @(posedge clk_i) begin
    if (!rst_ni && prog_we_i && !prog_dmem_i)
      imem[prog_addr_i[IAW-1:0]] <= prog_data_i[31:0];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni && prog_we_i && prog_dmem_i)
      dmem[prog_addr_i[DAW-1:0]] <= prog_data_i;
    else if (dm_we)
      dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic        rf_we,
  input logic        dm_we,
  input logic        br_taken,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] dbg_data_o,
  input logic [4:0]  dbg_addr_i
);
  logic known_op;
  assign known_op = instr[31:26] inside {6'd0, 6'd4, 6'd35, 6'd43};

  a_r1_reset_pc: assert property (@(posedge clk_i) !rst_ni |-> pc_q == 32'd0);

  a_r1_reset_no_write: assert property (@(posedge clk_i) !rst_ni |-> !rf_we && !dm_we);

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken |=> pc_q == $past(pc_q) + 32'd4);

  a_r5_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> pc_q == $past(pc_q) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  a_r5_taken_iff_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] == 6'd4) |-> (br_taken == (rs_val == rt_val)));

  a_r4_store_no_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we |-> !rf_we);

  a_r7_unknown_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_op |-> !rf_we && !dm_we && !br_taken);

  a_r6_zero_reg: assert property (@(posedge clk_i)
    dbg_addr_i == 5'd0 |-> dbg_data_o == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_q      (pc_q),
  .instr     (instr),
  .rf_we     (rf_we),
  .dm_we     (dm_we),
  .br_taken  (br_taken),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .dbg_data_o(dbg_data_o),
  .dbg_addr_i(dbg_addr_i)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic        prog_dmem_i = 1'b0;
  logic [5:0]  prog_addr_i = '0;
  logic [31:0] prog_data_i = '0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_data_o, pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] iprog [WORDS];
  logic [31:0] dinit [WORDS];

  sc_core uut (
    .clk_i, .rst_ni, .prog_we_i, .prog_dmem_i, .prog_addr_i, .prog_data_i,
    .dbg_addr_i, .dbg_data_o, .pc_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] rt_(input int rs, rt, rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_(input logic [5:0] op, input int rs, rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_is(input string req, input int idx, input logic [31:0] exp);
    dbg_addr_i = 5'(idx);
    #1;
    check(req, dbg_data_o, exp);
  endtask

  task automatic clear_images();
    for (int i = 0; i < WORDS; i++) begin
      iprog[i] = '0;
      dinit[i] = '0;
    end
  endtask

  // holds reset, writes both memories, leaves core in reset
  task automatic load_images();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 2*WORDS; i++) begin
      @(negedge clk_i);
      prog_we_i   = 1'b1;
      prog_dmem_i = (i >= WORDS);
      prog_addr_i = 6'(i % WORDS);
      prog_data_i = (i >= WORDS) ? dinit[i-WORDS] : iprog[i];
    end
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic run(input int n);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    clear_images();
    iprog[0] = rt_(0, 0, 1, 6'h20);
    load_images();
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 pc in reset", pc_o, 32'd0);
    reg_is("R1 reg in reset", 1, 32'd0);
    reg_is("R6 reg0", 0, 32'd0);
  endtask

  task automatic t_alu_mem();
    clear_images();
    dinit[0] = 32'd7; dinit[1] = 32'd5; dinit[2] = 32'hFFFF_FFFD;
    iprog[0]  = it_(6'd35, 0, 1, 0);
    iprog[1]  = it_(6'd35, 0, 2, 4);
    iprog[2]  = it_(6'd35, 0, 3, 8);
    iprog[3]  = rt_(1, 2, 4, 6'h20);
    iprog[4]  = rt_(1, 2, 5, 6'h22);
    iprog[5]  = rt_(1, 2, 6, 6'h24);
    iprog[6]  = rt_(1, 2, 7, 6'h25);
    iprog[7]  = rt_(3, 1, 8, 6'h2A);
    iprog[8]  = rt_(1, 3, 9, 6'h2A);
    iprog[9]  = rt_(1, 2, 0, 6'h20);
    iprog[10] = it_(6'd43, 0, 4, 12);
    iprog[11] = it_(6'd35, 0, 10, 12);
    iprog[12] = it_(6'd35, 4, 11, -4);
    iprog[13] = rt_(2, 2, 2, 6'h20);
    iprog[14] = it_(6'h3F, 1, 12, 0);
    iprog[15] = rt_(1, 1, 13, 6'h3F);
    load_images();
    run(16);
    check("R2 pc after 16", pc_o, 32'd64);
    reg_is("R4 lw", 1, 32'd7);
    reg_is("R4 lw neg data", 3, 32'hFFFF_FFFD);
    reg_is("R3 add", 4, 32'd12);
    reg_is("R3 sub", 5, 32'd2);
    reg_is("R3 and", 6, 32'd5);
    reg_is("R3 or", 7, 32'd7);
    reg_is("R3 slt signed true", 8, 32'd1);
    reg_is("R3 slt false", 9, 32'd0);
    reg_is("R6 write r0 ignored", 0, 32'd0);
    reg_is("R4 sw then lw", 10, 32'd12);
    reg_is("R4 negative offset", 11, 32'hFFFF_FFFD);
    reg_is("R8 old operand", 2, 32'd10);
    reg_is("R7 unknown opcode", 12, 32'd0);
    reg_is("R3 unknown funct", 13, 32'd0);
    // mid-run reset: state clears, nothing writes while held
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 pc cleared", pc_o, 32'd0);
    reg_is("R1 reg cleared", 4, 32'd0);
  endtask

  task automatic t_branch();
    clear_images();
    dinit[0] = 32'd7; dinit[1] = 32'd7; dinit[2] = 32'd9;
    iprog[0] = it_(6'd35, 0, 1, 0);
    iprog[1] = it_(6'd35, 0, 2, 4);
    iprog[2] = it_(6'd4, 1, 2, 2);
    iprog[3] = rt_(1, 2, 3, 6'h20);
    iprog[4] = rt_(1, 2, 3, 6'h20);
    iprog[5] = it_(6'd35, 0, 4, 8);
    iprog[6] = it_(6'd4, 1, 4, 5);
    iprog[7] = rt_(1, 4, 5, 6'h20);
    iprog[8] = it_(6'd4, 0, 0, -1);
    load_images();
    run(3);
    check("R5 taken target", pc_o, 32'd20);
    run(3);
    check("R5 not taken", pc_o, 32'd32);
    run(4);
    check("R5 backward self loop", pc_o, 32'd32);
    reg_is("R5 skipped", 3, 32'd0);
    reg_is("R5 fallthrough exec", 5, 32'd16);
    // load port while running must do nothing
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_dmem_i = 1'b0; prog_addr_i = 6'd8;
    prog_data_i = rt_(1, 1, 6, 6'h20);
    @(negedge clk_i);
    prog_dmem_i = 1'b1; prog_addr_i = 6'd2; prog_data_i = 32'd1;
    @(negedge clk_i);
    prog_we_i = 1'b0;
    run(3);
    check("R9 imem write ignored", pc_o, 32'd32);
    reg_is("R9 no effect reg", 6, 32'd0);
    // re-execute lw from word 2 via fresh run: reset keeps dmem
    clear_images();
    iprog[0] = it_(6'd35, 0, 7, 8);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_dmem_i = 1'b0; prog_addr_i = 6'd0; prog_data_i = iprog[0];
    @(negedge clk_i);
    prog_we_i = 1'b0;
    run(1);
    reg_is("R9 dmem write ignored", 7, 32'd9);
  endtask

  initial begin
    t_reset();
    t_alu_mem();
    t_branch();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule